// File: doc/BRIEF.md
# Polyphase Horizontal Downscaler with Transposed Output

The block resamples image rows horizontally with an 8-tap polyphase filter and writes every result transposed: the samples made from input row r land in column r of a local result buffer. Running the block a second time on that buffer gives vertical scaling, because the second pass again filters along rows.

For each output index the block walks a 32-bit fixed-point source position with 16 fractional bits. The integer part picks the base pixel and the top three fractional bits pick one of eight coefficient sets. The position starts from a programmable offset at the beginning of every row and moves by a programmable step after each output index. The dot product of eight same-component pixels with eight signed coefficients is rounded, shifted and clamped to 8 bits. In chroma mode the row carries interleaved blue-difference and red-difference bytes, and the two components are filtered separately.

The host programs the coefficients, then pulses `start` with the job settings. For each row it waits for `row_req`, loads the row into the line buffer and pulses `row_go`. After the last row, `done` pulses and the result is read through a synchronous address/data port. One sample is produced per clock, through fetch, multiply-accumulate and round/clamp stages.

Top module: `hsx_top`

## Requirements
- R1: After reset, `busy`, `done`, `cfg_err` and `row_req` are all 0.
- R2: Each result is S = sum over k=0..7 of pixel(k)*coef(phase,k), with pixels unsigned 8-bit and coefficients signed 8-bit; the stored value is (S+64)>>7 limited to 0..255.
- R3: A result whose rounded value is negative is stored as 0, and one above 255 is stored as 255.
- R4: The position P for output index i of every row is init + i*step (32 bits, wrapping). The base index is P[31:16] and the phase is P[15:13]; coefficient set p is written through `cf_phase`=p, tap k through `cf_tap`=k.
- R5: In luma mode (`cfg_chroma`=0), tap k reads line-buffer byte P[31:16] + 1 + k.
- R6: In chroma mode (`cfg_chroma`=1), component c (0 at even bytes, 1 at odd bytes) reads tap k from byte 2*P[31:16] + 2 + c + 2k; component 0 is stored at result row 2i and component 1 at row 2i+1.
- R7: A result from input row r (the r-th `row_go` after `start`, counted from 0) for output index i is stored at result row i (luma), column r.
- R8: A tap index at or beyond `cfg_row_len` reads the last loaded byte of the same component: byte len-1 in luma mode; in chroma mode, the highest byte below len whose parity equals c.
- R9: A `start` with `cfg_v_step` other than 0x00010000 sets `cfg_err` and starts no job (`busy` and `row_req` stay 0); a valid `start` clears `cfg_err`.
- R10: `busy` is 1 from the cycle after a valid `start` until `done`; `done` is a single-cycle pulse after the last sample of the last row is stored, and `busy` is 0 in that cycle.
- R11: `rd_data` shows the byte at (`rd_row`, `rd_col`) one clock after the address is applied and holds it until the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lb_we | input | 1 | Line-buffer write enable |
| lb_addr | input | 6 | Line-buffer byte address |
| lb_wdata | input | 8 | Line-buffer byte |
| cf_we | input | 1 | Coefficient write enable |
| cf_phase | input | 3 | Coefficient set (phase) to write |
| cf_tap | input | 3 | Tap within the set |
| cf_wdata | input | 8 | Signed coefficient |
| start | input | 1 | Accept job settings |
| cfg_out_w | input | 6 | Output indices per row (1..32, 1..16 in chroma) |
| cfg_rows | input | 6 | Rows in the job (1..32) |
| cfg_row_len | input | 7 | Valid bytes loaded per row |
| cfg_init_pos | input | 32 | Position at row start, 16 fractional bits |
| cfg_h_step | input | 32 | Position step per output index |
| cfg_v_step | input | 32 | Vertical step, must be 0x00010000 |
| cfg_chroma | input | 1 | 1 = interleaved two-component row |
| row_go | input | 1 | Loaded row may be processed |
| row_req | output | 1 | Block waits for the next row |
| busy | output | 1 | Job in progress |
| done | output | 1 | Pulse after the job's last stored sample |
| cfg_err | output | 1 | Last start was rejected |
| rd_row | input | 5 | Result read row |
| rd_col | input | 5 | Result read column |
| rd_data | output | 8 | Result byte, one cycle after address |

## Verification
The properties assume that the host raises `start` only while `busy` is low, loads the line buffer only while `row_req` is high, and gives `cfg_out_w` and `cfg_rows` values of at least 1 that fit the result buffer. The bench drives one scenario per task and never leaves that envelope: it waits for `row_req` before every load and for `done` before reading. Row lengths are at least two bytes in chroma jobs, so a same-component edge pixel always exists.

// File: rtl/hsx_pkg.sv
package hsx_pkg;

    localparam int PIX_W   = 8;
    localparam int COEF_W  = 8;
    localparam int TAPS    = 8;
    localparam int TAP_W   = $clog2(TAPS);
    localparam int PH_W    = 3;
    localparam int PHASES  = 1 << PH_W;
    localparam int FRAC_Q  = 16;
    localparam int POS_W   = 32;
    localparam int IPART_W = POS_W - FRAC_Q;
    localparam int IDX_W   = IPART_W + 2;
    localparam int SUM_W   = PIX_W + COEF_W + 1 + TAP_W;
    localparam int RND_SH  = 7;
    localparam logic [POS_W-1:0] ONE_STEP = POS_W'(1) << FRAC_Q;

    typedef logic [PIX_W-1:0]         pix_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [SUM_W-1:0]  sum_t;
    typedef logic signed [SUM_W:0]    rsum_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RUN,
        ST_DRAIN
    } st_e;

    typedef struct packed {
        logic [IPART_W-1:0] ipart;
        logic [PH_W-1:0]    phase;
        logic               comp;
    } issue_t;

    function automatic pix_t round_clamp(sum_t s);
        rsum_t t;
        t = $signed({s[SUM_W-1], s}) + $signed(rsum_t'(1 << (RND_SH - 1)));
        t = t >>> RND_SH;
        if (t < 0)
            return '0;
        else if (t > rsum_t'((1 << PIX_W) - 1))
            return '1;
        else
            return t[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/hsx_coef.sv
module hsx_coef
    import hsx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [PH_W-1:0]       wphase,
    input  logic [TAP_W-1:0]      wtap,
    input  coef_t                 wdata,
    input  logic [PH_W-1:0]       rphase,
    output coef_t [TAPS-1:0]      rtaps
);

    coef_t tbl [PHASES][TAPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < PHASES; p++)
                for (int k = 0; k < TAPS; k++)
                    tbl[p][k] <= '0;
        end else if (we) begin
            tbl[wphase][wtap] <= wdata;
        end
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_rd
        assign rtaps[k] = tbl[rphase][k];
    end

endmodule

// File: rtl/hsx_linebuf.sv
module hsx_linebuf
    import hsx_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
)(
    input  logic               clk,
    input  logic               we,
    input  logic [AW-1:0]      waddr,
    input  pix_t               wdata,
    input  logic [LW-1:0]      len,
    input  logic               chroma,
    input  issue_t             iss,
    output pix_t [TAPS-1:0]    taps
);

    pix_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    logic [IDX_W-1:0] base;
    logic [IDX_W-1:0] last;

    // Window origin and last usable byte of the selected component
    always_comb begin
        last = IDX_W'(len) - IDX_W'(1);
        if (chroma && (last[0] != iss.comp))
            last = last - IDX_W'(1);
        if (chroma)
            base = IDX_W'({iss.ipart, 1'b0}) + IDX_W'(2) + IDX_W'(iss.comp);
        else
            base = IDX_W'(iss.ipart) + IDX_W'(1);
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] sel;
        assign idx     = base + (chroma ? IDX_W'(2 * k) : IDX_W'(k));
        assign sel     = (idx > last) ? last : idx;
        assign taps[k] = mem[sel[AW-1:0]];
    end

endmodule

// File: rtl/hsx_ctrl.sv
module hsx_ctrl
    import hsx_pkg::*;
#(
    parameter int OUT_ROWS = 32,
    parameter int OUT_COLS = 32,
    parameter int LB_DEPTH = 64,
    localparam int OW = $clog2(OUT_ROWS) + 1,
    localparam int RW = $clog2(OUT_COLS) + 1,
    localparam int RA = $clog2(OUT_ROWS),
    localparam int CA = $clog2(OUT_COLS),
    localparam int LW = $clog2(LB_DEPTH) + 1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OW-1:0]     cfg_out_w,
    input  logic [RW-1:0]     cfg_rows,
    input  logic [LW-1:0]     cfg_row_len,
    input  logic [POS_W-1:0]  cfg_init_pos,
    input  logic [POS_W-1:0]  cfg_h_step,
    input  logic [POS_W-1:0]  cfg_v_step,
    input  logic              cfg_chroma,
    input  logic              row_go,
    input  logic              pipe_empty,
    output logic              issue_v,
    output issue_t            iss,
    output logic              chroma_q,
    output logic [LW-1:0]     len_q,
    output logic [RA-1:0]     dst_row,
    output logic [CA-1:0]     dst_col,
    output logic              busy,
    output logic              row_req,
    output logic              done,
    output logic              cfg_err
);

    st_e              st;
    logic [OW-1:0]    out_w_q;
    logic [RW-1:0]    rows_q;
    logic [POS_W-1:0] init_q;
    logic [POS_W-1:0] step_q;
    logic [POS_W-1:0] pos;
    logic [OW-1:0]    idx;
    logic [RW-1:0]    row_cnt;
    logic             comp;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cfg_err  <= 1'b0;
            done     <= 1'b0;
            out_w_q  <= '0;
            rows_q   <= '0;
            init_q   <= '0;
            step_q   <= '0;
            chroma_q <= 1'b0;
            len_q    <= '0;
            pos      <= '0;
            idx      <= '0;
            row_cnt  <= '0;
            comp     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        if (cfg_v_step != ONE_STEP) begin
                            cfg_err <= 1'b1;
                        end else begin
                            cfg_err  <= 1'b0;
                            out_w_q  <= cfg_out_w;
                            rows_q   <= cfg_rows;
                            init_q   <= cfg_init_pos;
                            step_q   <= cfg_h_step;
                            chroma_q <= cfg_chroma;
                            len_q    <= cfg_row_len;
                            row_cnt  <= '0;
                            st       <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (row_go) begin
                        pos  <= init_q;
                        idx  <= '0;
                        comp <= 1'b0;
                        st   <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (chroma_q && !comp) begin
                        comp <= 1'b1;
                    end else begin
                        comp <= 1'b0;
                        pos  <= pos + step_q;
                        if (idx == out_w_q - OW'(1))
                            st <= ST_DRAIN;
                        else
                            idx <= idx + OW'(1);
                    end
                end
                ST_DRAIN: begin
                    if (pipe_empty) begin
                        if (row_cnt == rows_q - RW'(1)) begin
                            done <= 1'b1;
                            st   <= ST_IDLE;
                        end else begin
                            row_cnt <= row_cnt + RW'(1);
                            st      <= ST_WAIT;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign issue_v   = (st == ST_RUN);
    assign iss.ipart = pos[POS_W-1:FRAC_Q];
    assign iss.phase = pos[FRAC_Q-1 -: PH_W];
    assign iss.comp  = comp;
    assign dst_row   = chroma_q ? RA'({idx, comp}) : RA'(idx);
    assign dst_col   = CA'(row_cnt);
    assign busy      = (st != ST_IDLE);
    assign row_req   = (st == ST_WAIT);

endmodule

// File: rtl/hsx_tbuf.sv
module hsx_tbuf
    import hsx_pkg::*;
#(
    parameter int ROWS = 32,
    parameter int COLS = 32,
    localparam int RA = $clog2(ROWS),
    localparam int CA = $clog2(COLS),
    localparam int AW = $clog2(ROWS * COLS)
)(
    input  logic          clk,
    input  logic          we,
    input  logic [RA-1:0] wrow,
    input  logic [CA-1:0] wcol,
    input  pix_t          wdata,
    input  logic [RA-1:0] rrow,
    input  logic [CA-1:0] rcol,
    output pix_t          rdata
);

    pix_t mem [ROWS * COLS];

    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;

    assign waddr = AW'(wrow) * AW'(COLS) + AW'(wcol);
    assign raddr = AW'(rrow) * AW'(COLS) + AW'(rcol);

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/hsx_top.sv
module hsx_top
    import hsx_pkg::*;
#(
    parameter int LB_DEPTH = 64,
    parameter int OUT_ROWS = 32,
    parameter int OUT_COLS = 32,
    localparam int LA = $clog2(LB_DEPTH),
    localparam int LW = LA + 1,
    localparam int OW = $clog2(OUT_ROWS) + 1,
    localparam int RW = $clog2(OUT_COLS) + 1,
    localparam int RA = $clog2(OUT_ROWS),
    localparam int CA = $clog2(OUT_COLS)
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lb_we,
    input  logic [LA-1:0]        lb_addr,
    input  logic [PIX_W-1:0]     lb_wdata,
    input  logic                 cf_we,
    input  logic [PH_W-1:0]      cf_phase,
    input  logic [TAP_W-1:0]     cf_tap,
    input  logic [COEF_W-1:0]    cf_wdata,
    input  logic                 start,
    input  logic [OW-1:0]        cfg_out_w,
    input  logic [RW-1:0]        cfg_rows,
    input  logic [LW-1:0]        cfg_row_len,
    input  logic [POS_W-1:0]     cfg_init_pos,
    input  logic [POS_W-1:0]     cfg_h_step,
    input  logic [POS_W-1:0]     cfg_v_step,
    input  logic                 cfg_chroma,
    input  logic                 row_go,
    output logic                 row_req,
    output logic                 busy,
    output logic                 done,
    output logic                 cfg_err,
    input  logic [RA-1:0]        rd_row,
    input  logic [CA-1:0]        rd_col,
    output logic [PIX_W-1:0]     rd_data
);

    logic            issue_v;
    issue_t          iss;
    logic            chroma_q;
    logic [LW-1:0]   len_q;
    logic [RA-1:0]   dst_row;
    logic [CA-1:0]   dst_col;
    logic            pipe_empty;
    pix_t [TAPS-1:0]  f_px;
    coef_t [TAPS-1:0] f_cf;

    hsx_ctrl #(
        .OUT_ROWS (OUT_ROWS),
        .OUT_COLS (OUT_COLS),
        .LB_DEPTH (LB_DEPTH)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .cfg_out_w    (cfg_out_w),
        .cfg_rows     (cfg_rows),
        .cfg_row_len  (cfg_row_len),
        .cfg_init_pos (cfg_init_pos),
        .cfg_h_step   (cfg_h_step),
        .cfg_v_step   (cfg_v_step),
        .cfg_chroma   (cfg_chroma),
        .row_go       (row_go),
        .pipe_empty   (pipe_empty),
        .issue_v      (issue_v),
        .iss          (iss),
        .chroma_q     (chroma_q),
        .len_q        (len_q),
        .dst_row      (dst_row),
        .dst_col      (dst_col),
        .busy         (busy),
        .row_req      (row_req),
        .done         (done),
        .cfg_err      (cfg_err)
    );

    // Stage 1: gather taps and coefficients
    hsx_linebuf #(.DEPTH(LB_DEPTH)) u_lb (
        .clk    (clk),
        .we     (lb_we),
        .waddr  (lb_addr),
        .wdata  (lb_wdata),
        .len    (len_q),
        .chroma (chroma_q),
        .iss    (iss),
        .taps   (f_px)
    );

    hsx_coef u_coef (
        .clk    (clk),
        .rst    (rst),
        .we     (cf_we),
        .wphase (cf_phase),
        .wtap   (cf_tap),
        .wdata  (coef_t'(cf_wdata)),
        .rphase (iss.phase),
        .rtaps  (f_cf)
    );

    logic             s1_v;
    pix_t [TAPS-1:0]  s1_px;
    coef_t [TAPS-1:0] s1_cf;
    logic [RA-1:0]    s1_row;
    logic [CA-1:0]    s1_col;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v   <= 1'b0;
            s1_px  <= '0;
            s1_cf  <= '0;
            s1_row <= '0;
            s1_col <= '0;
        end else begin
            s1_v <= issue_v;
            if (issue_v) begin
                s1_px  <= f_px;
                s1_cf  <= f_cf;
                s1_row <= dst_row;
                s1_col <= dst_col;
            end
        end
    end

    // Stage 2: multiply-accumulate
    sum_t mac_sum;

    always_comb begin
        mac_sum = '0;
        for (int k = 0; k < TAPS; k++)
            mac_sum = mac_sum + sum_t'($signed({1'b0, s1_px[k]}) * s1_cf[k]);
    end

    logic          s2_v;
    sum_t          s2_sum;
    logic [RA-1:0] s2_row;
    logic [CA-1:0] s2_col;

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_v   <= 1'b0;
            s2_sum <= '0;
            s2_row <= '0;
            s2_col <= '0;
        end else begin
            s2_v <= s1_v;
            if (s1_v) begin
                s2_sum <= mac_sum;
                s2_row <= s1_row;
                s2_col <= s1_col;
            end
        end
    end

    assign pipe_empty = !s1_v && !s2_v;

    // Stage 3: round, clamp and store transposed
    logic wr_en;
    pix_t wr_pix;

    assign wr_en  = s2_v;
    assign wr_pix = round_clamp(s2_sum);

    hsx_tbuf #(.ROWS(OUT_ROWS), .COLS(OUT_COLS)) u_tbuf (
        .clk   (clk),
        .we    (wr_en),
        .wrow  (s2_row),
        .wcol  (s2_col),
        .wdata (wr_pix),
        .rrow  (rd_row),
        .rcol  (rd_col),
        .rdata (rd_data)
    );

endmodule

// File: rtl/hsx_chk.sv
module hsx_chk
    import hsx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [POS_W-1:0] cfg_v_step,
    input logic             busy,
    input logic             done,
    input logic             cfg_err,
    input logic             row_req,
    input logic             wr_en
);

    p_bad_cfg_r9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && cfg_v_step != ONE_STEP) |=> (cfg_err && !busy && !row_req));

    p_good_start_r10: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && cfg_v_step == ONE_STEP) |=> (busy && !cfg_err));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_end_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    p_store_in_job_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (busy && !row_req));

endmodule

bind hsx_top hsx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .cfg_v_step (cfg_v_step),
    .busy       (busy),
    .done       (done),
    .cfg_err    (cfg_err),
    .row_req    (row_req),
    .wr_en      (wr_en)
);

// File: tb/hsx_top_test.sv
module hsx_top_test;

    localparam int LBD  = 64;
    localparam int ORW  = 32;
    localparam int OCL  = 32;
    localparam int LA   = $clog2(LBD);
    localparam int LW   = LA + 1;
    localparam int OW   = $clog2(ORW) + 1;
    localparam int RW   = $clog2(OCL) + 1;
    localparam int RA   = $clog2(ORW);
    localparam int CA   = $clog2(OCL);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lb_we = 1'b0;
    logic [LA-1:0] lb_addr = '0;
    logic [7:0]    lb_wdata = '0;
    logic          cf_we = 1'b0;
    logic [2:0]    cf_phase = '0;
    logic [2:0]    cf_tap = '0;
    logic [7:0]    cf_wdata = '0;
    logic          start = 1'b0;
    logic [OW-1:0] cfg_out_w = '0;
    logic [RW-1:0] cfg_rows = '0;
    logic [LW-1:0] cfg_row_len = '0;
    logic [31:0]   cfg_init_pos = '0;
    logic [31:0]   cfg_h_step = '0;
    logic [31:0]   cfg_v_step = 32'h0001_0000;
    logic          cfg_chroma = 1'b0;
    logic          row_go = 1'b0;
    logic          row_req, busy, done, cfg_err;
    logic [RA-1:0] rd_row = '0;
    logic [CA-1:0] rd_col = '0;
    logic [7:0]    rd_data;

    hsx_top uut (.*);

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    int img [OCL][LBD];
    int cf  [8][8];
    int j_w, j_rows, j_len, j_chroma;
    longint j_init, j_step;

    task automatic check(string tag, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int ipart_of(int i);
        longint p;
        p = (j_init + longint'(i) * j_step) & 64'hFFFF_FFFF;
        return int'(p >> 16);
    endfunction

    function automatic int phase_of(int i);
        longint p;
        p = (j_init + longint'(i) * j_step) & 64'hFFFF_FFFF;
        return int'((p >> 13) & 7);
    endfunction

    function automatic int last_of(int c);
        int l;
        l = j_len - 1;
        if (j_chroma != 0 && (l % 2) != c) l = l - 1;
        return l;
    endfunction

    function automatic int model(int r, int i, int c);
        int ip, ph, idx;
        longint s;
        ip = ipart_of(i);
        ph = phase_of(i);
        s = 0;
        for (int k = 0; k < 8; k++) begin
            if (j_chroma != 0) idx = 2 * ip + 2 + c + 2 * k;
            else               idx = ip + 1 + k;
            if (idx > last_of(c)) idx = last_of(c);
            s += longint'(img[r][idx]) * cf[ph][k];
        end
        s += 64;
        if (s < 0) return 0;
        s = s / 128;
        if (s > 255) return 255;
        return int'(s);
    endfunction

    task automatic load_coefs();
        for (int p = 0; p < 8; p++)
            for (int k = 0; k < 8; k++) begin
                cf_we = 1'b1; cf_phase = 3'(p); cf_tap = 3'(k);
                cf_wdata = 8'(cf[p][k]);
                tick();
            end
        cf_we = 1'b0;
    endtask

    task automatic set_single_tap(int tap, int val);
        for (int p = 0; p < 8; p++)
            for (int k = 0; k < 8; k++)
                cf[p][k] = (k == tap) ? val : 0;
        load_coefs();
    endtask

    task automatic set_mixed_coefs();
        for (int p = 0; p < 8; p++)
            for (int k = 0; k < 8; k++)
                cf[p][k] = ((p * 29 + k * 17) % 41) - 8;
        load_coefs();
    endtask

    task automatic fill_img(int seed);
        for (int r = 0; r < OCL; r++)
            for (int k = 0; k < LBD; k++)
                img[r][k] = (r * 37 + k * 11 + seed * 53 + (k * k) % 7) & 255;
    endtask

    task automatic run_job(int w, int nrows, int len, longint init, longint step, int chroma);
        j_w = w; j_rows = nrows; j_len = len; j_init = init; j_step = step; j_chroma = chroma;
        cfg_out_w = OW'(w); cfg_rows = RW'(nrows); cfg_row_len = LW'(len);
        cfg_init_pos = 32'(init); cfg_h_step = 32'(step); cfg_chroma = chroma[0];
        cfg_v_step = 32'h0001_0000;
        start = 1'b1;
        tick();
        start = 1'b0;
        check("R10", int'(busy), 1, "busy after start");
        for (int r = 0; r < nrows; r++) begin
            while (!row_req) tick();
            for (int k = 0; k < len; k++) begin
                lb_we = 1'b1; lb_addr = LA'(k); lb_wdata = 8'(img[r][k]);
                tick();
            end
            lb_we = 1'b0;
            row_go = 1'b1;
            tick();
            row_go = 1'b0;
        end
        while (!done) tick();
        check("R10", int'(busy), 0, "busy during done");
        tick();
        check("R10", int'(done), 0, "done second cycle");
    endtask

    task automatic rd(int row, int col, output int v);
        rd_row = RA'(row); rd_col = CA'(col);
        tick();
        v = int'(rd_data);
    endtask

    task automatic verify_model(string tag);
        int v;
        for (int r = 0; r < j_rows; r++)
            for (int i = 0; i < j_w; i++)
                for (int c = 0; c <= j_chroma; c++) begin
                    rd((j_chroma != 0) ? 2 * i + c : i, r, v);
                    check(tag, v, model(r, i, c), $sformatf("row %0d idx %0d comp %0d", r, i, c));
                end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) tick();
        rst = 1'b0;
        tick();
        check("R1", int'(busy), 0, "busy");
        check("R1", int'(done), 0, "done");
        check("R1", int'(cfg_err), 0, "cfg_err");
        check("R1", int'(row_req), 0, "row_req");
    endtask

    // R5: tap 0 alone at 64 gives (pixel + 1) >> 1 of byte ipart + 1
    task automatic t_window();
        int v;
        fill_img(1);
        set_single_tap(0, 64);
        run_job(6, 2, 40, 64'h0002_0000, 64'h0003_0000, 0);
        for (int r = 0; r < 2; r++)
            for (int i = 0; i < 6; i++) begin
                rd(i, r, v);
                check("R5", v, (img[r][ipart_of(i) + 1] + 1) >> 1, $sformatf("row %0d idx %0d", r, i));
            end
    endtask

    // R2 R4 R7: fractional step, all phases hit, several rows
    task automatic t_poly();
        fill_img(2);
        set_mixed_coefs();
        run_job(12, 4, 48, 64'h0000_2000, 64'h0001_A000, 0);
        verify_model("R2 R4 R7");
        fill_img(5);
        run_job(9, 3, 40, 64'h0001_6000, 64'h0000_E000, 0);
        verify_model("R4");
    endtask

    // R3: large positive saturates to 255, negative to 0
    task automatic t_sat();
        int v;
        for (int r = 0; r < OCL; r++)
            for (int k = 0; k < LBD; k++)
                img[r][k] = 250;
        set_single_tap(0, 0);
        for (int p = 0; p < 8; p++)
            for (int k = 0; k < 8; k++) cf[p][k] = 127;
        load_coefs();
        run_job(4, 2, 30, 64'h0, 64'h0001_0000, 0);
        for (int i = 0; i < 4; i++) begin
            rd(i, 1, v);
            check("R3", v, 255, "high clamp");
        end
        for (int p = 0; p < 8; p++)
            for (int k = 0; k < 8; k++) cf[p][k] = -128;
        load_coefs();
        run_job(4, 2, 30, 64'h0, 64'h0001_0000, 0);
        for (int i = 0; i < 4; i++) begin
            rd(i, 0, v);
            check("R3", v, 0, "low clamp");
        end
    endtask

    // R6: interleaved components, rows 2i and 2i+1
    task automatic t_chroma();
        int v;
        fill_img(3);
        set_mixed_coefs();
        run_job(8, 3, 50, 64'h0000_4000, 64'h0001_4000, 1);
        verify_model("R6");
        set_single_tap(0, 64);
        run_job(6, 2, 40, 64'h0001_0000, 64'h0002_0000, 1);
        for (int r = 0; r < 2; r++)
            for (int i = 0; i < 6; i++) begin
                rd(2 * i, r, v);
                check("R6", v, (img[r][2 * ipart_of(i) + 2] + 1) >> 1, "first component");
                rd(2 * i + 1, r, v);
                check("R6", v, (img[r][2 * ipart_of(i) + 3] + 1) >> 1, "second component");
            end
    endtask

    // R8: taps past the loaded length replicate the last same-component byte
    task automatic t_edge();
        int v, idx;
        fill_img(4);
        set_single_tap(7, 64);
        run_job(8, 2, 10, 64'h0, 64'h0002_0000, 0);
        for (int r = 0; r < 2; r++)
            for (int i = 0; i < 8; i++) begin
                idx = ipart_of(i) + 8;
                if (idx > 9) idx = 9;
                rd(i, r, v);
                check("R8", v, (img[r][idx] + 1) >> 1, $sformatf("luma idx %0d", i));
            end
        run_job(5, 2, 13, 64'h0, 64'h0001_0000, 1);
        for (int r = 0; r < 2; r++)
            for (int i = 0; i < 5; i++) begin
                idx = 2 * ipart_of(i) + 16;
                if (idx > 12) idx = 12;
                rd(2 * i, r, v);
                check("R8", v, (img[r][idx] + 1) >> 1, "chroma first comp edge");
                idx = 2 * ipart_of(i) + 17;
                if (idx > 11) idx = 11;
                rd(2 * i + 1, r, v);
                check("R8", v, (img[r][idx] + 1) >> 1, "chroma second comp edge");
            end
        set_mixed_coefs();
        run_job(8, 2, 12, 64'h0000_8000, 64'h0001_C000, 0);
        verify_model("R8");
    endtask

    // R9: bad vertical step rejected, good start clears the flag
    task automatic t_cfg();
        cfg_v_step = 32'h0000_8000;
        start = 1'b1;
        tick();
        start = 1'b0;
        check("R9", int'(cfg_err), 1, "cfg_err set");
        check("R9", int'(busy), 0, "busy after bad start");
        repeat (5) tick();
        check("R9", int'(row_req), 0, "row_req after bad start");
        check("R9", int'(busy), 0, "busy stays low");
        fill_img(6);
        set_mixed_coefs();
        run_job(3, 1, 20, 64'h0, 64'h0001_8000, 0);
        check("R9", int'(cfg_err), 0, "cfg_err cleared");
        verify_model("R9");
    endtask

    // R11: one-cycle read latency, output held until next edge
    task automatic t_read();
        int v;
        rd(0, 0, v);
        check("R11", v, model(0, 0, 0), "first read");
        rd_row = RA'(1);
        #1;
        check("R11", int'(rd_data), model(0, 0, 0), "held before edge");
        tick();
        check("R11", int'(rd_data), model(0, 1, 0), "after edge");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_window();
        t_poly();
        t_sat();
        t_chroma();
        t_edge();
        t_cfg();
        t_read();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule